// File: doc/BRIEF.md
# Page-Walk Helper and Translation Entry Loader

This block sits beside a 32-slot translation buffer and serves a software miss handler. When a translation misses, the block captures the faulting page number and its address-space tag. The handler then reads two registers that do not return their stored contents. Instead they return the memory addresses of the first-level and second-level page-table entries for that page. Each address is formed by adding page-number bits, scaled by four, to a table base that software wrote earlier.

The handler places segment attributes (protection group, guarded flag, page-size code, segment-valid) and the second-level table base in a segment register. It then writes the real-page word. That single write builds a complete entry from the page, segment and real-page registers. The entry appears on the entry outputs with a one-cycle write strobe, aimed at the slot held in the control register. The slot index then advances by itself, and a reserve flag can shield the four lowest slots from replacement.

Register select codes: 0 control, 1 page, 2 segment / second-level address, 3 first-level base / address, 4 real-page word. Reads are combinational. Other codes read as zero and ignore writes.

Top module: `walk_assist_loader`

## Requirements
- R1: After reset the control register reads 0x04000000, so the slot index is 0 and the reserve flag is clear. The page register reads 0, and `ent_we` is low.
- R2: A write to the page register keeps the page number in bits 31:12, the valid bit in bit 9 and the address-space tag in bits 3:0. A readback equals the written word ANDed with 0xFFFFF20F.
- R3: When `miss_valid` is high at an edge, the page register loads `miss_page` into bits 31:12 and `miss_asid` into bits 3:0, and bit 9 is set. A miss takes priority over a software write to the page register in the same cycle.
- R4: A read of select 3 returns the first-level base (bits 31:12 of the last word written to select 3) plus page-number bits 19:10 times four.
- R5: A read of select 2 returns the second-level base (bits 31:12 of the last word written to select 2) plus page-number bits 9:0 times four.
- R6: A write to select 4 raises `ent_we` for exactly the next cycle. In that cycle the entry carries the page number, the tag, the write word in `ent_rpn`, the segment group (bits 8:5), guarded (bit 4) and size code (bits 3:2), and valid = page valid AND segment valid (bit 0). Select 4 later reads back the written word.
- R7: With the reserve flag clear, each entry write stores into the current index and then increments the index, and 31 wraps to 0. The index reads back in control bits 12:8.
- R8: With the reserve flag (control bit 27) set, an index below 4 is raised to 4 before the store, and the index advances from 31 back to 4. Slots 0 to 3 are never written.
- R9: `ent_offmask` gives the in-page offset bits above the 4 KB offset: code 3 (8 MB) gives 0x7FF, code 1 (512 KB) gives 0x07F, and codes 0 and 2 give 0.
- R10: The control register keeps only bits 27, 26 and 12:8. Every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr | input | 1 | Register write strobe |
| sr_sel | input | 3 | Register select |
| sr_wdata | input | 32 | Register write data |
| sr_rdata | output | 32 | Register read data (combinational) |
| miss_valid | input | 1 | Miss capture strobe |
| miss_page | input | 20 | Faulting page number (address bits 31:12) |
| miss_asid | input | 4 | Faulting address-space tag |
| ent_we | output | 1 | One-cycle entry write strobe |
| ent_idx | output | 5 | Target slot |
| ent_epn | output | 20 | Entry page number |
| ent_asid | output | 4 | Entry address-space tag |
| ent_valid | output | 1 | Entry valid |
| ent_group | output | 4 | Protection group |
| ent_guard | output | 1 | Guarded flag |
| ent_psize | output | 2 | Page-size code |
| ent_offmask | output | 11 | Extra offset mask for large pages |
| ent_rpn | output | 32 | Real-page word |

## Verification
The bench runs each slot index through the wrap from 31, with and without the reserve flag. A design with a wrong wrap target would overwrite slots 0 to 3 or skip slots. It starts a reserved run with an index below 4, to catch a design that clamps only at the wrap point. It collides a miss with a page-register write, which exposes inverted priority as a lost faulting page. It sweeps captured pages so that a wrong bit slice or scale in either table-address adder shows up as a shifted address. It also tries all four size codes, to catch a swapped 8 MB / 512 KB mask.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int DW = 32;
  localparam int SELW = 3;

  typedef enum logic [SELW-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_PAGE  = 3'd1,
    SEL_SEG   = 3'd2,
    SEL_TBASE = 3'd3,
    SEL_REAL  = 3'd4
  } sel_e;

  localparam logic [DW-1:0] CTRL_RST = 32'h0400_0000;

  // first-level entry address: base + page[19:10]*4
  function automatic logic [DW-1:0] l1_slot_addr(logic [19:0] base, logic [19:0] page);
    return {base, 12'h000} + {20'h0, page[19:10], 2'b00};
  endfunction

  // second-level entry address: base + page[9:0]*4
  function automatic logic [DW-1:0] l2_slot_addr(logic [19:0] base, logic [19:0] page);
    return {base, 12'h000} + {20'h0, page[9:0], 2'b00};
  endfunction

  // offset bits beyond the 4 KB page offset covered by a size code
  function automatic logic [10:0] size_offmask(logic [1:0] code);
    case (code)
      2'b11:   return 11'h7FF;
      2'b01:   return 11'h07F;
      default: return 11'h000;
    endcase
  endfunction
endpackage

// File: rtl/walk_regs.sv
module walk_regs #(
  parameter int IDXW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            sel,
  input  logic [31:0]           wdata,
  input  logic                  miss_valid,
  input  logic [19:0]           miss_page,
  input  logic [3:0]            miss_asid,
  input  logic                  adv_en,
  input  logic [IDXW-1:0]       adv_idx,
  output logic                  wr_real,
  output logic                  rsv_q,
  output logic                  hw_q,
  output logic [IDXW-1:0]       idx_q,
  output logic [19:0]           page_q,
  output logic                  pvalid_q,
  output logic [3:0]            asid_q,
  output logic [19:0]           l1base_q,
  output logic [19:0]           l2base_q,
  output logic [3:0]            group_q,
  output logic                  guard_q,
  output logic [1:0]            psize_q,
  output logic                  svalid_q,
  output logic [31:0]           real_q
);
  import walk_pkg::*;

  logic wr_ctrl, wr_page, wr_seg, wr_tbase;
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
  assign wr_page  = wr_en && (sel == SEL_PAGE);
  assign wr_seg   = wr_en && (sel == SEL_SEG);
  assign wr_tbase = wr_en && (sel == SEL_TBASE);
  assign wr_real  = wr_en && (sel == SEL_REAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_q <= CTRL_RST[27];
      hw_q  <= CTRL_RST[26];
      idx_q <= '0;
    end else if (wr_ctrl) begin
      rsv_q <= wdata[27];
      hw_q  <= wdata[26];
      idx_q <= wdata[8 +: IDXW];
    end else if (adv_en) begin
      idx_q <= adv_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      pvalid_q <= 1'b0;
      asid_q   <= '0;
    end else if (miss_valid) begin
      page_q   <= miss_page;
      pvalid_q <= 1'b1;
      asid_q   <= miss_asid;
    end else if (wr_page) begin
      page_q   <= wdata[31:12];
      pvalid_q <= wdata[9];
      asid_q   <= wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2base_q <= '0;
      group_q  <= '0;
      guard_q  <= 1'b0;
      psize_q  <= '0;
      svalid_q <= 1'b0;
    end else if (wr_seg) begin
      l2base_q <= wdata[31:12];
      group_q  <= wdata[8:5];
      guard_q  <= wdata[4];
      psize_q  <= wdata[3:2];
      svalid_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        l1base_q <= '0;
    else if (wr_tbase) l1base_q <= wdata[31:12];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       real_q <= '0;
    else if (wr_real) real_q <= wdata;
  end
endmodule

// File: rtl/walk_readmux.sv
module walk_readmux #(
  parameter int IDXW = 5
) (
  input  logic [2:0]      sel,
  input  logic            rsv_q,
  input  logic            hw_q,
  input  logic [IDXW-1:0] idx_q,
  input  logic [19:0]     page_q,
  input  logic            pvalid_q,
  input  logic [3:0]      asid_q,
  input  logic [19:0]     l1base_q,
  input  logic [19:0]     l2base_q,
  input  logic [31:0]     real_q,
  output logic [31:0]     rdata
);
  import walk_pkg::*;

  logic [31:0] ctrl_word, page_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[27] = rsv_q;
    ctrl_word[26] = hw_q;
    ctrl_word[8 +: IDXW] = idx_q;
  end

  always_comb begin
    page_word = '0;
    page_word[31:12] = page_q;
    page_word[9] = pvalid_q;
    page_word[3:0] = asid_q;
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rdata = ctrl_word;
      SEL_PAGE:  rdata = page_word;
      SEL_SEG:   rdata = l2_slot_addr(l2base_q, page_q);
      SEL_TBASE: rdata = l1_slot_addr(l1base_q, page_q);
      SEL_REAL:  rdata = real_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/walk_commit.sv
module walk_commit #(
  parameter int ENTRIES = 32,
  parameter int RSV = 4,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_real,
  input  logic [31:0]     wdata,
  input  logic            rsv_q,
  input  logic [IDXW-1:0] idx_q,
  input  logic [19:0]     page_q,
  input  logic            pvalid_q,
  input  logic [3:0]      asid_q,
  input  logic [3:0]      group_q,
  input  logic            guard_q,
  input  logic [1:0]      psize_q,
  input  logic            svalid_q,
  output logic            adv_en,
  output logic [IDXW-1:0] adv_idx,
  output logic            ent_we,
  output logic [IDXW-1:0] ent_idx,
  output logic [19:0]     ent_epn,
  output logic [3:0]      ent_asid,
  output logic            ent_valid,
  output logic [3:0]      ent_group,
  output logic            ent_guard,
  output logic [1:0]      ent_psize,
  output logic [10:0]     ent_offmask,
  output logic [31:0]     ent_rpn
);
  import walk_pkg::*;

  function automatic logic [IDXW-1:0] target_slot(logic [IDXW-1:0] cur, logic keep);
    return (keep && (cur < IDXW'(RSV))) ? IDXW'(RSV) : cur;
  endfunction

  function automatic logic [IDXW-1:0] next_slot(logic [IDXW-1:0] cur, logic keep);
    if (cur >= IDXW'(ENTRIES - 1)) return keep ? IDXW'(RSV) : '0;
    return cur + 1'b1;
  endfunction

  logic [IDXW-1:0] slot;
  assign slot    = target_slot(idx_q, rsv_q);
  assign adv_en  = wr_real;
  assign adv_idx = next_slot(slot, rsv_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ent_we <= 1'b0;
    else        ent_we <= wr_real;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_idx     <= '0;
      ent_epn     <= '0;
      ent_asid    <= '0;
      ent_valid   <= 1'b0;
      ent_group   <= '0;
      ent_guard   <= 1'b0;
      ent_psize   <= '0;
      ent_offmask <= '0;
      ent_rpn     <= '0;
    end else if (wr_real) begin
      ent_idx     <= slot;
      ent_epn     <= page_q;
      ent_asid    <= asid_q;
      ent_valid   <= pvalid_q & svalid_q;
      ent_group   <= group_q;
      ent_guard   <= guard_q;
      ent_psize   <= psize_q;
      ent_offmask <= size_offmask(psize_q);
      ent_rpn     <= wdata;
    end
  end
endmodule

// File: rtl/walk_assist_loader.sv
module walk_assist_loader #(
  parameter int ENTRIES = 32,
  parameter int RSV = 4,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_wr,
  input  logic [2:0]      sr_sel,
  input  logic [31:0]     sr_wdata,
  output logic [31:0]     sr_rdata,
  input  logic            miss_valid,
  input  logic [19:0]     miss_page,
  input  logic [3:0]      miss_asid,
  output logic            ent_we,
  output logic [IDXW-1:0] ent_idx,
  output logic [19:0]     ent_epn,
  output logic [3:0]      ent_asid,
  output logic            ent_valid,
  output logic [3:0]      ent_group,
  output logic            ent_guard,
  output logic [1:0]      ent_psize,
  output logic [10:0]     ent_offmask,
  output logic [31:0]     ent_rpn
);
  // named events and state for the bound checker
  logic            wr_real, adv_en;
  logic [IDXW-1:0] adv_idx, idx_q;
  logic            rsv_q, hw_q;
  logic [19:0]     page_q, l1base_q, l2base_q;
  logic            pvalid_q, guard_q, svalid_q;
  logic [3:0]      asid_q, group_q;
  logic [1:0]      psize_q;
  logic [31:0]     real_q;

  walk_regs #(.IDXW(IDXW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(sr_wr), .sel(sr_sel), .wdata(sr_wdata),
    .miss_valid(miss_valid), .miss_page(miss_page), .miss_asid(miss_asid),
    .adv_en(adv_en), .adv_idx(adv_idx), .wr_real(wr_real),
    .rsv_q(rsv_q), .hw_q(hw_q), .idx_q(idx_q), .page_q(page_q),
    .pvalid_q(pvalid_q), .asid_q(asid_q), .l1base_q(l1base_q),
    .l2base_q(l2base_q), .group_q(group_q), .guard_q(guard_q),
    .psize_q(psize_q), .svalid_q(svalid_q), .real_q(real_q)
  );

  walk_readmux #(.IDXW(IDXW)) rmux_i (
    .sel(sr_sel), .rsv_q(rsv_q), .hw_q(hw_q), .idx_q(idx_q), .page_q(page_q),
    .pvalid_q(pvalid_q), .asid_q(asid_q), .l1base_q(l1base_q),
    .l2base_q(l2base_q), .real_q(real_q), .rdata(sr_rdata)
  );

  walk_commit #(.ENTRIES(ENTRIES), .RSV(RSV), .IDXW(IDXW)) commit_i (
    .clk(clk), .rst_n(rst_n), .wr_real(wr_real), .wdata(sr_wdata),
    .rsv_q(rsv_q), .idx_q(idx_q), .page_q(page_q), .pvalid_q(pvalid_q),
    .asid_q(asid_q), .group_q(group_q), .guard_q(guard_q),
    .psize_q(psize_q), .svalid_q(svalid_q),
    .adv_en(adv_en), .adv_idx(adv_idx),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_epn(ent_epn),
    .ent_asid(ent_asid), .ent_valid(ent_valid), .ent_group(ent_group),
    .ent_guard(ent_guard), .ent_psize(ent_psize),
    .ent_offmask(ent_offmask), .ent_rpn(ent_rpn)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int RSV = 4,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_real,
  input logic            ent_we,
  input logic [IDXW-1:0] ent_idx,
  input logic            rsv_q,
  input logic [IDXW-1:0] idx_q,
  input logic            miss_valid,
  input logic [19:0]     miss_page,
  input logic [19:0]     page_q,
  input logic            pvalid_q
);
  assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_real |=> ent_we);

  assert_no_stray_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |-> $past(wr_real));

  assert_low_slots_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_we && $past(rsv_q)) |-> (ent_idx >= IDXW'(RSV)));

  assert_index_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_real) && !$past(rsv_q)) |-> (idx_q == IDXW'($past(idx_q) + 1'b1)));

  assert_miss_captured_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (page_q == $past(miss_page) && pvalid_q));
endmodule

bind walk_assist_loader walk_checker #(.RSV(RSV), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_real(wr_real), .ent_we(ent_we),
  .ent_idx(ent_idx), .rsv_q(rsv_q), .idx_q(idx_q), .miss_valid(miss_valid),
  .miss_page(miss_page), .page_q(page_q), .pvalid_q(pvalid_q)
);

// File: tb/walk_assist_loader_tb_top.sv
module walk_assist_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_wr = 1'b0;
  logic [2:0]  sr_sel = 3'd0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_page = '0;
  logic [3:0]  miss_asid = '0;
  logic        ent_we, ent_valid, ent_guard;
  logic [4:0]  ent_idx;
  logic [19:0] ent_epn;
  logic [3:0]  ent_asid, ent_group;
  logic [1:0]  ent_psize;
  logic [10:0] ent_offmask;
  logic [31:0] ent_rpn;

  int total = 0;
  int fails = 0;
  int exp_idx = 0;
  logic exp_rsv = 1'b0;

  always #4 clk = ~clk;

  walk_assist_loader dut_i (
    .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_sel(sr_sel),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .miss_valid(miss_valid),
    .miss_page(miss_page), .miss_asid(miss_asid), .ent_we(ent_we),
    .ent_idx(ent_idx), .ent_epn(ent_epn), .ent_asid(ent_asid),
    .ent_valid(ent_valid), .ent_group(ent_group), .ent_guard(ent_guard),
    .ent_psize(ent_psize), .ent_offmask(ent_offmask), .ent_rpn(ent_rpn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    sr_sel = s;
    #1 v = sr_rdata;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    sr_wr = 1'b1; sr_sel = s; sr_wdata = d;
    @(posedge clk); @(negedge clk);
    sr_wr = 1'b0;
  endtask

  task automatic miss(input logic [19:0] p, input logic [3:0] a);
    miss_valid = 1'b1; miss_page = p; miss_asid = a;
    @(posedge clk); @(negedge clk);
    miss_valid = 1'b0;
  endtask

  // commit and check the slot chosen by the bench's own model
  task automatic commit_slot(string req, logic [31:0] word);
    logic [31:0] v;
    int slot;
    slot = (exp_rsv && exp_idx < 4) ? 4 : exp_idx;
    wr(3'd4, word);
    chk({req, " strobe"}, {31'b0, ent_we}, 32'd1);
    chk({req, " slot"}, {27'b0, ent_idx}, slot);
    exp_idx = (slot == 31) ? (exp_rsv ? 4 : 0) : slot + 1;
    rd(3'd0, v);
    chk({req, " next index"}, {27'b0, v[12:8]}, exp_idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0400_0000);
    rd(3'd1, v); chk("R1 page", v, 32'h0);
    chk("R1 strobe", {31'b0, ent_we}, 32'd0);

    // R2 page register masking
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      d = 32'h9E37_79B9 * (i + 1) ^ (32'hFFFF_FFFF >> i);
      wr(3'd1, d);
      rd(3'd1, v); chk("R2 page readback", v, d & 32'hFFFF_F20F);
    end

    // R10 control register keeps only its fields
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R10 ctrl mask", v, 32'h0C00_1F00);
    wr(3'd0, 32'h0400_0000);
    rd(3'd0, v); chk("R10 ctrl restore", v, 32'h0400_0000);

    // R3/R4/R5 miss capture and table addresses
    wr(3'd3, 32'hABCD_EFFF);
    wr(3'd2, 32'h1234_5000);
    for (int i = 0; i < 16; i++) begin
      logic [19:0] p;
      logic [3:0] a;
      p = 20'(32'h0003_1F17 * (i + 3) + i * 20'h4_0401);
      a = 4'(i * 7);
      miss(p, a);
      rd(3'd1, v);
      chk("R3 captured page", v, ({12'b0, p} << 12) | 32'h200 | {28'b0, a});
      rd(3'd3, v);
      chk("R4 level-1 address", v, 32'hABCD_E000 + ({22'b0, p[19:10]} * 4));
      rd(3'd2, v);
      chk("R5 level-2 address", v, 32'h1234_5000 + ({22'b0, p[9:0]} * 4));
    end

    // R3 miss wins over same-cycle page write
    sr_wr = 1'b1; sr_sel = 3'd1; sr_wdata = 32'h0000_0000;
    miss_valid = 1'b1; miss_page = 20'hF00D5; miss_asid = 4'hA;
    @(posedge clk); @(negedge clk);
    sr_wr = 1'b0; miss_valid = 1'b0;
    rd(3'd1, v); chk("R3 miss priority", v, 32'hF00D_520A);

    // R6/R9 entry build across all size codes
    for (int ps = 0; ps < 4; ps++) begin
      for (int sv = 0; sv < 2; sv++) begin
        logic [31:0] seg, rw, om;
        int grp;
        grp = (ps * 5 + sv * 3) & 15;
        seg = 32'h7654_3000 | (grp << 5) | ((ps & 1) << 4) | (ps << 2) | sv;
        wr(3'd2, seg);
        wr(3'd1, 32'h8765_4203);
        rw = 32'hC0DE_0000 + ps * 16 + sv;
        commit_slot("R6", rw);
        chk("R6 page", {12'b0, ent_epn}, 32'h87654);
        chk("R6 tag", {28'b0, ent_asid}, 32'h3);
        chk("R6 valid", {31'b0, ent_valid}, sv);
        chk("R6 group", {28'b0, ent_group}, grp);
        chk("R6 guard", {31'b0, ent_guard}, ps & 1);
        chk("R6 size", {30'b0, ent_psize}, ps);
        chk("R6 word", ent_rpn, rw);
        om = (ps == 3) ? (32'd1 << (23 - 12)) - 1 : (ps == 1) ? (32'd1 << (19 - 12)) - 1 : 0;
        chk("R9 offset mask", {21'b0, ent_offmask}, om);
        rd(3'd4, v); chk("R6 word readback", v, rw);
        @(posedge clk); @(negedge clk);
        chk("R6 single strobe", {31'b0, ent_we}, 32'd0);
      end
    end

    // R7 plain wrap
    wr(3'd0, 32'h0000_1C00);
    exp_rsv = 1'b0; exp_idx = 28;
    for (int k = 0; k < 8; k++) commit_slot("R7", 32'h1000 * k);

    // R8 reserve: raise from below 4, then wrap to 4
    wr(3'd0, 32'h0800_0200);
    exp_rsv = 1'b1; exp_idx = 2;
    commit_slot("R8 raise", 32'h5);
    wr(3'd0, 32'h0800_1D00);
    exp_idx = 29;
    for (int k = 0; k < 34; k++) commit_slot("R8", 32'h2000 * k);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule